// File: doc/BRIEF.md
# Two-Plane Scrolled Shade Scan-Out

This block produces the pixel stream for a 160 by 152 display with four grey levels. The image is held in two separate one-bit-per-pixel planes. Each plane is a 256 by 256 image in its own 8 KB synchronous RAM. The block steps a pixel/line/frame counter and places a scrolled window over the planes. For each group of eight pixels it reads one byte from each plane. It then shifts the bits out one per clock and pairs the bit from each plane into a 2-bit shade. Pixel-valid, line-start and frame-start strobes travel with the shade.

Both planes receive the same read address. Each RAM must return its data one clock after that address is presented. The scroll offsets, the plane-swap control and the blank control are sampled once per frame, on the first pixel of the frame. The CPU can therefore rewrite them at any time without tearing the picture. Each plane byte holds eight horizontally adjacent pixels, with the leftmost pixel in bit 7. A plane row is 32 bytes, so the byte address is row * 32 + (x / 8).

Top module: `lcd_scan_top`

## Requirements
- R1: After reset is released, frame_start_o first goes high after the third rising clock edge. It then repeats every H_TOTAL*V_TOTAL cycles. line_start_o goes high together with the first valid pixel of every visible line, every H_TOTAL cycles. Both strobes and pix_valid_o are low during reset.
- R2: In each visible line, pix_valid_o is high for exactly 160 consecutive cycles starting with line_start_o. There are 152 visible lines per frame. Elsewhere pix_valid_o is low and shade_o is 0.
- R3: Screen pixel (x, line) is taken from plane column fx = x + scroll and row ry. The bit used is bit (7 - fx mod 8) of byte address ry*32 + fx/8, with the data returned one cycle after the address. With swap low, shade_o = {plane1 bit, plane0 bit}.
- R4: The horizontal plane column wraps modulo 256: fx = (x + scroll_x_i) mod 256.
- R5: The plane row is (line + scroll_y) minus 200 when that sum is 200 or more. The row bits of plane_addr_o (bits 12:5) never reach 200.
- R6: A scroll_y_i value of 200 or above is treated as 199.
- R7: With swap_i high, shade_o = {plane0 bit, plane1 bit}.
- R8: With blank_i high, shade_o is 0 on every pixel, while pix_valid_o, line_start_o and frame_start_o keep their normal timing.
- R9: scroll_x_i, scroll_y_i, swap_i and blank_i are sampled only on the clock edge that starts a frame. Changes at any other time have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scroll_x_i | input | 8 | Horizontal plane offset |
| scroll_y_i | input | 8 | Vertical plane offset, limited to 199 |
| swap_i | input | 1 | Plane 0 supplies the shade MSB when high |
| blank_i | input | 1 | Forces shade to 0 when high |
| plane_addr_o | output | 13 | Byte read address shared by both plane RAMs |
| plane0_rdata_i | input | 8 | Plane 0 byte, one cycle after the address |
| plane1_rdata_i | input | 8 | Plane 1 byte, one cycle after the address |
| pix_valid_o | output | 1 | Current shade belongs to a visible pixel |
| shade_o | output | 2 | Pixel shade, 0 is lightest |
| line_start_o | output | 1 | First pixel of a visible line |
| frame_start_o | output | 1 | First pixel of a frame |

## Verification
The hardest cases to reach are the two wrap seams and the mid-frame register change. The horizontal seam needs a scroll that makes a single byte group cross column 255 back to 0. The vertical seam needs a scroll that makes line plus offset pass 200 partway down the frame. The mid-frame case needs the controls to change while the frame is still being drawn. The bench runs five whole frames, each with its own scroll, swap and blank set: wrap at column 253, row wrap at line 140, an out-of-range vertical offset, a blanked frame and a large mixed offset. Halfway through every frame it drives inverted junk onto every control, and it compares every output on every cycle against values computed from a pattern function that stands in for the RAMs.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int BYTE_BITS = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_BITS);
  localparam int NUM_PLANES = 2;

  typedef struct packed {
    logic                 valid;
    logic                 line_first;
    logic                 frame_first;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 fetch;
    logic                 swap;
    logic                 blank;
  } pix_tag_t;
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int H_ACTIVE = 160,
  parameter int V_ACTIVE = 152,
  parameter int H_TOTAL  = 168,
  parameter int V_TOTAL  = 156,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          active_o,
  output logic          line_first_o,
  output logic          frame_first_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_last, v_last, v_vis;

  assign h_last = (h_q == HW'(H_TOTAL - 1));
  assign v_last = (v_q == VW'(V_TOTAL - 1));
  assign v_vis  = (v_q < VW'(V_ACTIVE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_last) begin
      h_q <= '0;
      v_q <= v_last ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o           = h_q;
  assign v_o           = v_q;
  assign active_o      = v_vis && (h_q < HW'(H_ACTIVE));
  assign line_first_o  = v_vis && (h_q == '0);
  assign frame_first_o = (v_q == '0) && (h_q == '0);
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch
  import lcd_scan_pkg::*;
#(
  parameter int H_TOTAL  = 168,
  parameter int V_TOTAL  = 156,
  parameter int PLANE_W  = 256,
  parameter int PLANE_H  = 256,
  parameter int ROW_WRAP = 200,
  localparam int HW     = $clog2(H_TOTAL),
  localparam int VW     = $clog2(V_TOTAL),
  localparam int X_W    = $clog2(PLANE_W),
  localparam int ROW_W  = $clog2(PLANE_H),
  localparam int COL_W  = X_W - BIT_IDX_W,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW-1:0]     h_i,
  input  logic [VW-1:0]     v_i,
  input  logic              active_i,
  input  logic              line_first_i,
  input  logic              frame_first_i,
  input  logic [X_W-1:0]    scroll_x_i,
  input  logic [ROW_W-1:0]  scroll_y_i,
  input  logic              swap_i,
  input  logic              blank_i,
  output logic [ADDR_W-1:0] addr_o,
  output pix_tag_t          tag_o
);
  logic [X_W-1:0]   sx_q, sx;
  logic [ROW_W-1:0] sy_q, sy, sy_clip;
  logic             swap_q, blank_q, swap_c, blank_c;
  logic [X_W-1:0]   fx;
  logic [ROW_W:0]   row_sum, row;
  logic             fetch;
  logic [ADDR_W-1:0] addr_q;
  pix_tag_t         tag_q;

  // frame config is taken live on the frame's first pixel, held afterwards
  assign sx      = frame_first_i ? scroll_x_i : sx_q;
  assign sy      = frame_first_i ? scroll_y_i : sy_q;
  assign swap_c  = frame_first_i ? swap_i     : swap_q;
  assign blank_c = frame_first_i ? blank_i    : blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sx_q    <= '0;
      sy_q    <= '0;
      swap_q  <= 1'b0;
      blank_q <= 1'b0;
    end else if (frame_first_i) begin
      sx_q    <= scroll_x_i;
      sy_q    <= scroll_y_i;
      swap_q  <= swap_i;
      blank_q <= blank_i;
    end
  end

  assign sy_clip = (sy >= ROW_W'(ROW_WRAP)) ? ROW_W'(ROW_WRAP - 1) : sy;
  assign row_sum = {1'b0, ROW_W'(v_i)} + {1'b0, sy_clip};
  assign row     = (row_sum >= (ROW_W+1)'(ROW_WRAP)) ? row_sum - (ROW_W+1)'(ROW_WRAP) : row_sum;
  assign fx      = sx + X_W'(h_i);
  assign fetch   = line_first_i || (fx[BIT_IDX_W-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      tag_q  <= '0;
    end else begin
      tag_q.valid       <= active_i;
      tag_q.line_first  <= line_first_i;
      tag_q.frame_first <= frame_first_i;
      tag_q.bit_idx     <= fx[BIT_IDX_W-1:0];
      tag_q.fetch       <= fetch;
      tag_q.swap        <= swap_c;
      tag_q.blank       <= blank_c;
      if (active_i && fetch) addr_q <= {row[ROW_W-1:0], fx[X_W-1:BIT_IDX_W]};
    end
  end

  assign addr_o = addr_q;
  assign tag_o  = tag_q;
endmodule

// File: rtl/lcd_scan_shade.sv
module lcd_scan_shade
  import lcd_scan_pkg::*;
(
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  pix_tag_t                              tag_i,
  input  logic [NUM_PLANES-1:0][BYTE_BITS-1:0]  rdata_i,
  output logic                                  pix_valid_o,
  output logic [NUM_PLANES-1:0]                 shade_o,
  output logic                                  line_start_o,
  output logic                                  frame_start_o
);
  pix_tag_t                              tag_q;
  logic [NUM_PLANES-1:0][BYTE_BITS-1:0]  held_q;
  logic [NUM_PLANES-1:0][BYTE_BITS-1:0]  cur_byte;
  logic [NUM_PLANES-1:0]                 pix_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else         tag_q <= tag_i;
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    // fresh byte arrives on a fetch cycle, otherwise keep shifting the held one
    assign cur_byte[p] = tag_q.fetch ? rdata_i[p] : held_q[p];
    assign pix_bit[p]  = cur_byte[p][~tag_q.bit_idx];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          held_q[p] <= '0;
      else if (tag_q.valid) held_q[p] <= cur_byte[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o   <= 1'b0;
      shade_o       <= '0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      pix_valid_o   <= tag_q.valid;
      line_start_o  <= tag_q.valid && tag_q.line_first;
      frame_start_o <= tag_q.valid && tag_q.frame_first;
      if (!tag_q.valid || tag_q.blank) shade_o <= '0;
      else if (tag_q.swap)             shade_o <= {pix_bit[0], pix_bit[1]};
      else                             shade_o <= {pix_bit[1], pix_bit[0]};
    end
  end
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
  import lcd_scan_pkg::*;
#(
  parameter int H_ACTIVE = 160,
  parameter int V_ACTIVE = 152,
  parameter int H_TOTAL  = 168,
  parameter int V_TOTAL  = 156,
  parameter int PLANE_W  = 256,
  parameter int PLANE_H  = 256,
  parameter int ROW_WRAP = 200,
  localparam int HW     = $clog2(H_TOTAL),
  localparam int VW     = $clog2(V_TOTAL),
  localparam int X_W    = $clog2(PLANE_W),
  localparam int ROW_W  = $clog2(PLANE_H),
  localparam int ADDR_W = ROW_W + X_W - BIT_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [X_W-1:0]    scroll_x_i,
  input  logic [ROW_W-1:0]  scroll_y_i,
  input  logic              swap_i,
  input  logic              blank_i,
  output logic [ADDR_W-1:0] plane_addr_o,
  input  logic [7:0]        plane0_rdata_i,
  input  logic [7:0]        plane1_rdata_i,
  output logic              pix_valid_o,
  output logic [1:0]        shade_o,
  output logic              line_start_o,
  output logic              frame_start_o
);
  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic          active, line_first, frame_first;
  pix_tag_t      tag_s1;
  logic [NUM_PLANES-1:0][BYTE_BITS-1:0] rdata;

  assign rdata[0] = plane0_rdata_i;
  assign rdata[1] = plane1_rdata_i;

  lcd_scan_timing #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
  ) u_timing (
    .clk_i, .rst_ni,
    .h_o(h), .v_o(v), .active_o(active),
    .line_first_o(line_first), .frame_first_o(frame_first)
  );

  lcd_scan_fetch #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .PLANE_W(PLANE_W),
    .PLANE_H(PLANE_H), .ROW_WRAP(ROW_WRAP)
  ) u_fetch (
    .clk_i, .rst_ni,
    .h_i(h), .v_i(v), .active_i(active),
    .line_first_i(line_first), .frame_first_i(frame_first),
    .scroll_x_i, .scroll_y_i, .swap_i, .blank_i,
    .addr_o(plane_addr_o), .tag_o(tag_s1)
  );

  lcd_scan_shade u_shade (
    .clk_i, .rst_ni,
    .tag_i(tag_s1), .rdata_i(rdata),
    .pix_valid_o, .shade_o, .line_start_o, .frame_start_o
  );
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int H_ACTIVE = 160,
  parameter int H_TOTAL  = 168,
  parameter int ROW_WRAP = 200,
  parameter int ADDR_W   = 13,
  localparam int RUN_W   = $clog2(H_ACTIVE + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] plane_addr_o,
  input logic              pix_valid_o,
  input logic [1:0]        shade_o,
  input logic              line_start_o,
  input logic              frame_start_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (line_start_o) run_q <= RUN_W'(1);
    else if (pix_valid_o)  run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  // R2
  idle_shade_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_o |-> (shade_o == 2'b00));

  // R2
  line_run_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_valid_o && $past(pix_valid_o)) |-> (run_q == RUN_W'(H_ACTIVE)));

  // R1
  frame_on_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (line_start_o && pix_valid_o));

  // R1
  line_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> (pix_valid_o && (H_TOTAL == H_ACTIVE || !$past(pix_valid_o))));

  // R5
  row_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plane_addr_o[ADDR_W-1:5] < 8'(ROW_WRAP));
endmodule

bind lcd_scan_top lcd_scan_chk #(
  .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .ROW_WRAP(ROW_WRAP), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .plane_addr_o(plane_addr_o),
  .pix_valid_o(pix_valid_o), .shade_o(shade_o),
  .line_start_o(line_start_o), .frame_start_o(frame_start_o)
);

// File: tb/tb_lcd_scan_top.sv
`timescale 1ns/1ps
module tb_lcd_scan_top;
  localparam int HA = 160, VA = 152, HT = 168, VT = 156;
  localparam int FT = HT * VT;
  localparam int NF = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  scroll_x_i, scroll_y_i;
  logic        swap_i, blank_i;
  logic [12:0] plane_addr_o;
  logic [7:0]  plane0_rdata_i, plane1_rdata_i;
  logic        pix_valid_o, line_start_o, frame_start_o;
  logic [1:0]  shade_o;

  int n_vec = 0;
  int n_bad = 0;

  int    cfg_sx [NF] = '{0, 253, 5, 9, 120};
  int    cfg_sy [NF] = '{0, 60, 230, 7, 199};
  bit    cfg_sw [NF] = '{0, 0, 1, 0, 0};
  bit    cfg_bl [NF] = '{0, 0, 0, 1, 0};
  string cfg_tag[NF] = '{"R3 R9", "R4 R5 R9", "R6 R7 R9", "R8 R9", "R5 R9"};

  always #5 clk_i = ~clk_i;

  lcd_scan_top dut (
    .clk_i, .rst_ni, .scroll_x_i, .scroll_y_i, .swap_i, .blank_i,
    .plane_addr_o, .plane0_rdata_i, .plane1_rdata_i,
    .pix_valid_o, .shade_o, .line_start_o, .frame_start_o
  );

  function automatic logic [7:0] pat0(int a);
    return 8'(a * 37 + (a >> 5) * 11 + 3);
  endfunction

  function automatic logic [7:0] pat1(int a);
    return 8'((a ^ (a >> 4)) * 5 + 91);
  endfunction

  // synchronous RAM stand-ins, one-cycle read
  always @(posedge clk_i) begin
    plane0_rdata_i <= pat0(int'(plane_addr_o));
    plane1_rdata_i <= pat1(int'(plane_addr_o));
  end

  task automatic drive_cfg(int f, bit junk);
    scroll_x_i = 8'(cfg_sx[f]) ^ (junk ? 8'h5a : 8'h00);
    scroll_y_i = 8'(cfg_sy[f]) ^ (junk ? 8'h21 : 8'h00);
    swap_i     = cfg_sw[f] ^ junk;
    blank_i    = cfg_bl[f] ^ junk;
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      if (n_bad < 30) $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_cycle(int k);
    int p, f, r, ln, x, fx, syc, row, a;
    bit vld, ls, fs, b0, b1;
    int sh;
    p = k - 3;
    vld = 0; ls = 0; fs = 0; sh = 0; f = 0;
    if (p >= 0) begin
      f = p / FT; r = p % FT; ln = r / HT; x = r % HT;
      vld = (ln < VA) && (x < HA);
      ls  = vld && (x == 0);
      fs  = ls && (ln == 0);
      if (vld && f < NF) begin
        fx  = (x + cfg_sx[f]) % 256;
        syc = (cfg_sy[f] >= 200) ? 199 : cfg_sy[f];
        row = (ln + syc) % 200;
        a   = row * 32 + fx / 8;
        b0  = pat0(a)[7 - fx % 8];
        b1  = pat1(a)[7 - fx % 8];
        if (cfg_bl[f])      sh = 0;
        else if (cfg_sw[f]) sh = {b0, b1};
        else                sh = {b1, b0};
      end
    end
    cmp("R1", "frame_start_o", int'(frame_start_o), int'(fs));
    cmp("R1", "line_start_o", int'(line_start_o), int'(ls));
    cmp("R2", "pix_valid_o", int'(pix_valid_o), int'(vld));
    cmp((f < NF) ? cfg_tag[f] : "R2", "shade_o", int'(shade_o), sh);
  endtask

  initial begin
    drive_cfg(0, 0);
    repeat (3) begin
      @(negedge clk_i);
      // R1 reset state
      check_cycle(-10);
    end
    rst_ni = 1'b1;
    for (int k = 1; k <= NF * FT + 4; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      check_cycle(k);
      for (int f = 0; f < NF; f++) begin
        if (k == f * FT + FT / 2) drive_cfg(f, 1);            // R9 mid-frame junk
        if (f + 1 < NF && k == (f + 1) * FT - 20) drive_cfg(f + 1, 0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule